// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and a weekday index. A free-running 32768 Hz enable input is divided down to a one-second step. The step ripples through the fields with month lengths and leap years taken into account. A host reaches the block through a byte-wide register bus with address, write data, write strobe, read strobe and a registered read-data return.

Software stops the clock, loads a new time field by field and starts it again. To read a coherent time while the clock runs, it first requests a snapshot, which freezes a shadow copy of all seven fields. It then selects the shadow copy for reads, so a multi-byte read cannot straddle a carry. Two further control bits round the time to the nearest minute and present the hour in 12-hour form. A 16-bit compensation value is held in two byte registers for use by other logic.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control register reads 0x00, so the clock is stopped, and the status register reads 0x00.
- R2: Register map: 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year, 0x06 weekday (bits 2:0), 0x08 control, 0x09 status, 0x0A compensation low byte, 0x0B compensation high byte. Other addresses read 0x00. Read data appears on the clock edge that samples the read strobe and holds while the strobe is low.
- R3: While control bit 0 is 1, seconds advance once every DIV_COUNT pulses of the 32768 Hz enable. While bit 0 is 0, no field advances and the pulse divider returns to zero.
- R4: Seconds and minutes wrap 0x59 to 0x00, and hours wrap 0x23 to 0x00, each carrying into the next field. Every day change advances the weekday, which wraps 6 to 0.
- R5: Day wraps to 0x01 after 0x31, 0x30 or 0x28 depending on the month. February ends at 0x29 when the year's value is divisible by 4, including 00. Month wraps 0x12 to 0x01 and carries into the year, which wraps 0x99 to 0x00.
- R6: Writing 1 to control bit 6 copies all seven live fields into the shadow registers on the following clock edge. The bit then reads 0 again. The shadow copy does not change until the next request.
- R7: With control bit 7 set, reads of 0x00 to 0x06 return the shadow copy. With it clear, they return the live fields.
- R8: Writing 1 to control bit 1 rounds the time on the following edge and the bit then reads 0. Seconds become 0x00. If seconds were 0x30 or more, minutes advance by one with the full carry chain of R4 and R5.
- R9: With control bit 3 set, the hours register reads 0x01 to 0x12 with bit 7 set for the afternoon: 00h reads 0x12, 13h reads 0x81, 12h reads 0x92. Hours are always written in 24-hour form.
- R10: Status bit 1 reads the value control bit 0 had one cycle earlier. All other status bits read 0.
- R11: The compensation bytes and control bit 2 store and read back what was written, with no effect on timekeeping. Control bits 5:4 always read 0.
- R12: A bus write to a time field takes effect even when a one-second step falls on the same edge; that step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable pulse at 32768 Hz |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions check on every cycle the things that hold at any time. The divider count stays in range and clears while stopped. Seconds increment within a decade, and a month-end step lands on day 0x01 and moves the weekday. A snapshot copies the live time exactly, the snapshot and round requests self-clear, and the status bit follows the run bit. A field write beats a coincident step, and read data holds while no read is strobed. Only the bench scenarios can show the actual calendar results: that month ends, leap Februaries and the century wrap produce the right BCD values. They also show that the shadow copy stays frozen while the live time moves on, that rounding carries correctly, and that the 12-hour presentation is right.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam int C_RUN    = 0;
  localparam int C_ROUND  = 1;
  localparam int C_AUTO   = 2;
  localparam int C_12H    = 3;
  localparam int C_SNAP   = 6;
  localparam int C_SHADOW = 7;
  localparam logic [7:0] CTRL_WMASK = 8'hCF;

  typedef logic [NUM_FIELDS-1:0][7:0] cal_t;

  // weekday, year, month, day, hour, minute, second
  localparam cal_t CAL_RESET = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'h0};
    return b + 8'd1;
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'h0, b[7:4]} * 8'd10) + {4'h0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v - tens * 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = bcd2bin(yr);
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] to_12h(input logic [7:0] h);
    logic [7:0] hb, h12;
    logic pm;
    hb  = bcd2bin(h);
    pm  = (hb >= 8'd12);
    h12 = pm ? hb - 8'd12 : hb;
    if (h12 == 8'd0) h12 = 8'd12;
    return {pm, bin2bcd(h12)[6:0]};
  endfunction

  // Advance by one second (from_min=0) or by one minute (from_min=1).
  function automatic cal_t cal_step(input cal_t t, input logic from_min);
    cal_t r;
    logic c;
    r = t;
    c = 1'b1;
    if (!from_min) begin
      if (t[F_SEC] == 8'h59) r[F_SEC] = 8'h00;
      else begin r[F_SEC] = bcd_inc(t[F_SEC]); c = 1'b0; end
    end
    if (c) begin
      if (t[F_MIN] == 8'h59) r[F_MIN] = 8'h00;
      else begin r[F_MIN] = bcd_inc(t[F_MIN]); c = 1'b0; end
    end
    if (c) begin
      if (t[F_HOUR] == 8'h23) r[F_HOUR] = 8'h00;
      else begin r[F_HOUR] = bcd_inc(t[F_HOUR]); c = 1'b0; end
    end
    if (c) begin
      r[F_WDAY] = (t[F_WDAY] >= 8'd6) ? 8'd0 : t[F_WDAY] + 8'd1;
      if (t[F_DAY] == month_len(t[F_MON], t[F_YEAR])) r[F_DAY] = 8'h01;
      else begin r[F_DAY] = bcd_inc(t[F_DAY]); c = 1'b0; end
    end
    if (c) begin
      if (t[F_MON] == 8'h12) r[F_MON] = 8'h01;
      else begin r[F_MON] = bcd_inc(t[F_MON]); c = 1'b0; end
    end
    if (c) r[F_YEAR] = (t[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(t[F_YEAR]);
    return r;
  endfunction
endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick_in,
  output logic sec_pulse
);
  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign sec_pulse = run && tick_in && (cnt == LAST);

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == '0);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       round_req,
  input  logic       sec_pulse,
  output cal_t       live
);
  cal_t rounded;

  always_comb begin
    rounded = (live[F_SEC] >= 8'h30) ? cal_step(live, 1'b1) : live;
    rounded[F_SEC] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) live <= CAL_RESET;
    else if (wr_en) begin
      if (int'(wr_idx) == F_WDAY) live[wr_idx] <= {5'b0, wr_data[2:0]};
      else                        live[wr_idx] <= wr_data;
    end
    else if (round_req) live <= rounded;
    else if (sec_pulse) live <= cal_step(live, 1'b0);
  end

  a_r4_sec_digit: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !wr_en && !round_req && live[F_SEC][3:0] < 4'd9)
      |=> live[F_SEC][3:0] == $past(live[F_SEC][3:0]) + 4'd1);
  a_r5_month_end: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !wr_en && !round_req && live[F_SEC] == 8'h59 && live[F_MIN] == 8'h59 &&
     live[F_HOUR] == 8'h23 && live[F_DAY] == month_len(live[F_MON], live[F_YEAR]))
      |=> (live[F_DAY] == 8'h01) && (live[F_WDAY] != $past(live[F_WDAY])));
  a_r8_round_zero: assert property (@(posedge clk) disable iff (rst)
    (round_req && !wr_en) |=> live[F_SEC] == 8'h00);
  a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 3'd0) |=> live[F_SEC] == $past(wr_data));
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import rtc_cal_pkg::*;
#(
  parameter int DIV_COUNT = 32768,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] A_TIME_END = ADDR_W'(NUM_FIELDS - 1);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_COMP_LO  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_COMP_HI  = ADDR_W'(11);

  logic [7:0] ctrl_q, comp_lo, comp_hi, rd_val, fld;
  logic       run_q, sec_pulse, time_wr, ctrl_wr;
  cal_t       live, shadow, src;

  assign time_wr = bus_we && (bus_addr <= A_TIME_END);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  rtc_sec_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk(clk), .rst(rst), .run(ctrl_q[C_RUN]), .tick_in(tick_32k), .sec_pulse(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .wr_en(time_wr), .wr_idx(bus_addr[2:0]), .wr_data(bus_wdata),
    .round_req(ctrl_q[C_ROUND]), .sec_pulse(sec_pulse), .live(live)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)                 shadow[i] <= CAL_RESET[i];
      else if (ctrl_q[C_SNAP]) shadow[i] <= live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 8'h00;
      comp_lo <= 8'h00;
      comp_hi <= 8'h00;
      run_q   <= 1'b0;
    end else begin
      run_q <= ctrl_q[C_RUN];
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_WMASK;
      else begin
        ctrl_q[C_SNAP]  <= 1'b0;
        ctrl_q[C_ROUND] <= 1'b0;
      end
      if (bus_we && bus_addr == A_COMP_LO) comp_lo <= bus_wdata;
      if (bus_we && bus_addr == A_COMP_HI) comp_hi <= bus_wdata;
    end
  end

  always_comb begin
    src = ctrl_q[C_SHADOW] ? shadow : live;
    fld = src[bus_addr[2:0]];
    if (int'(bus_addr) == F_HOUR && ctrl_q[C_12H]) fld = to_12h(fld);
    if (bus_addr <= A_TIME_END)     rd_val = fld;
    else if (bus_addr == A_CTRL)    rd_val = ctrl_q;
    else if (bus_addr == A_STAT)    rd_val = {6'b0, run_q, 1'b0};
    else if (bus_addr == A_COMP_LO) rd_val = comp_lo;
    else if (bus_addr == A_COMP_HI) rd_val = comp_hi;
    else                            rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_re) bus_rdata <= rd_val;
  end

  a_r6_snap_copy: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_SNAP] |=> shadow == $past(live));
  a_r6_snap_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_SNAP] && !ctrl_wr) |=> !ctrl_q[C_SNAP]);
  a_r8_round_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_ROUND] && !ctrl_wr) |=> !ctrl_q[C_ROUND]);
  a_r10_status_run: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> run_q == $past(ctrl_q[C_RUN]));
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/test_bcd_clock_core.sv
module test_bcd_clock_core;
  localparam int DIV = 4;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  bcd_clock_core #(.DIV_COUNT(DIV), .ADDR_W(4)) i_bcd_clock_core (
    .clk(clk), .rst(rst), .tick_32k(tick), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata)
  );

  // ---------------- behavioural reference model ----------------
  int lv[7], sh[7];
  int ctrl, runq, clo, chi, divc, exp_rd;

  function automatic int to_bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int from_bcd(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_step(bit from_min);
    if (!from_min) begin lv[0]++; if (lv[0] < 60) return; lv[0] = 0; end
    lv[1]++; if (lv[1] < 60) return; lv[1] = 0;
    lv[2]++; if (lv[2] < 24) return; lv[2] = 0;
    lv[6] = (lv[6] + 1) % 7;
    lv[3]++; if (lv[3] <= mdays(lv[4], lv[5])) return; lv[3] = 1;
    lv[4]++; if (lv[4] <= 12) return; lv[4] = 1;
    lv[5] = (lv[5] + 1) % 100;
  endtask

  function automatic int m_read(int a);
    int v, h;
    if (a <= 6) begin
      v = ((ctrl & 8'h80) != 0) ? sh[a] : lv[a];
      if (a == 6) return v;
      if (a == 2 && (ctrl & 8'h08) != 0) begin
        h = v % 12; if (h == 0) h = 12;
        return ((v >= 12) ? 128 : 0) | to_bcd(h);
      end
      return to_bcd(v);
    end
    case (a)
      8: return ctrl;
      9: return runq << 1;
      10: return clo;
      11: return chi;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    lv = '{0, 0, 0, 1, 1, 0, 0}; sh = lv;
    ctrl = 0; runq = 0; clo = 0; chi = 0; divc = 0; exp_rd = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (rst) m_reset();
    else begin
      int pre_ctrl;
      bit sec_evt;
      pre_ctrl = ctrl;
      if (re) exp_rd = m_read(int'(addr));
      sec_evt = ((pre_ctrl & 1) != 0) && tick && (divc == DIV - 1);
      if ((pre_ctrl & 1) == 0) divc = 0;
      else if (tick) divc = (divc == DIV - 1) ? 0 : divc + 1;
      if ((pre_ctrl & 8'h40) != 0) sh = lv;
      if (we && addr <= 6) lv[addr] = (addr == 6) ? (int'(wdata) & 7) : from_bcd(int'(wdata));
      else if ((pre_ctrl & 8'h02) != 0) begin
        if (lv[0] >= 30) m_step(1'b1);
        lv[0] = 0;
      end
      else if (sec_evt) m_step(1'b0);
      runq = pre_ctrl & 1;
      if (we && addr == 8) ctrl = int'(wdata) & 8'hCF;
      else ctrl = ctrl & ~8'h42;
      if (we && addr == 10) clo = int'(wdata);
      if (we && addr == 11) chi = int'(wdata);
    end
  end

  logic [3:0] last_rd_addr = '0;
  always @(posedge clk) if (re) last_rd_addr <= addr;

  function automatic string tag_of(logic [3:0] a);
    if (a <= 6) return "R5";
    if (a == 8) return "R6";
    if (a == 9) return "R10";
    if (a == 10 || a == 11) return "R11";
    return "R2";
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if (int'(rdata) != exp_rd) begin
        mismatched++;
        $display("FAIL %s model compare addr=%0h actual=%02h expected=%02h",
                 tag_of(last_rd_addr), last_rd_addr, rdata, exp_rd[7:0]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    compared++;
    if (rdata !== e) begin
      mismatched++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, a, rdata, e);
    end
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [7:0] s, mi, h, d, mo, y, w);
    wr(4'h8, 8'h00);
    wr(4'h0, s); wr(4'h1, mi); wr(4'h2, h); wr(4'h3, d);
    wr(4'h4, mo); wr(4'h5, y); wr(4'h6, w);
  endtask

  task automatic roll_case(input logic [7:0] d, mo, y, ed, emo, ey, input string req);
    load(8'h59, 8'h59, 8'h23, d, mo, y, 8'h02);
    wr(4'h8, 8'h01);
    pulses(DIV);
    wr(4'h8, 8'h00);
    rd(4'h3, ed, req); rd(4'h4, emo, req); rd(4'h5, ey, req);
    rd(4'h0, 8'h00, req); rd(4'h6, 8'h03, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h0, 8'h00, "R1"); rd(4'h1, 8'h00, "R1"); rd(4'h2, 8'h00, "R1");
    rd(4'h3, 8'h01, "R1"); rd(4'h4, 8'h01, "R1"); rd(4'h5, 8'h00, "R1");
    rd(4'h6, 8'h00, "R1"); rd(4'h8, 8'h00, "R1"); rd(4'h9, 8'h00, "R1");
    rd(4'h7, 8'h00, "R2"); rd(4'hF, 8'h00, "R2");

    // R11 compensation and inert control bits
    wr(4'hA, 8'h5A); wr(4'hB, 8'hA5);
    rd(4'hA, 8'h5A, "R11"); rd(4'hB, 8'hA5, "R11");
    wr(4'h8, 8'h34); rd(4'h8, 8'h04, "R11");

    // R3 divider and R4/R5 leap day with weekday wrap
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h06);
    wr(4'h8, 8'h01);
    pulses(DIV - 1);
    rd(4'h0, 8'h59, "R3");
    pulses(1);
    rd(4'h0, 8'h00, "R4"); rd(4'h2, 8'h00, "R4"); rd(4'h6, 8'h00, "R4");
    rd(4'h3, 8'h29, "R5"); rd(4'h4, 8'h02, "R5");
    pulses(2);
    wr(4'h8, 8'h00); wr(4'h8, 8'h01);
    pulses(DIV - 1);
    rd(4'h0, 8'h00, "R3");
    pulses(1);
    rd(4'h0, 8'h01, "R3");
    wr(4'h8, 8'h00);
    pulses(DIV);
    rd(4'h0, 8'h01, "R3");

    // R10 status follows run
    idle(1); rd(4'h9, 8'h00, "R10");
    wr(4'h8, 8'h01); idle(1); rd(4'h9, 8'h02, "R10");

    // R5 month, leap and year boundaries
    roll_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R5");
    roll_case(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "R5");
    roll_case(8'h29, 8'h02, 8'h96, 8'h01, 8'h03, 8'h96, "R5");
    roll_case(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00, "R5");
    roll_case(8'h30, 8'h04, 8'h25, 8'h01, 8'h05, 8'h25, "R5");
    roll_case(8'h30, 8'h01, 8'h25, 8'h31, 8'h01, 8'h25, "R5");

    // R6 / R7 snapshot and shadow select
    load(8'h56, 8'h34, 8'h12, 8'h15, 8'h07, 8'h21, 8'h03);
    wr(4'h8, 8'h01);
    wr(4'h8, 8'hC1); idle(1);
    rd(4'h8, 8'h81, "R6");
    pulses(2 * DIV);
    rd(4'h0, 8'h56, "R7"); rd(4'h1, 8'h34, "R7"); rd(4'h3, 8'h15, "R6");
    wr(4'h8, 8'h01);
    rd(4'h0, 8'h58, "R7");
    wr(4'h8, 8'hC1); idle(1);
    rd(4'h0, 8'h58, "R6");
    wr(4'h8, 8'h00);

    // R8 rounding
    load(8'h45, 8'h59, 8'h10, 8'h05, 8'h05, 8'h05, 8'h01);
    wr(4'h8, 8'h02); idle(1);
    rd(4'h0, 8'h00, "R8"); rd(4'h1, 8'h00, "R8"); rd(4'h2, 8'h11, "R8");
    rd(4'h8, 8'h00, "R8");
    load(8'h29, 8'h10, 8'h10, 8'h05, 8'h05, 8'h05, 8'h01);
    wr(4'h8, 8'h02); idle(1);
    rd(4'h0, 8'h00, "R8"); rd(4'h1, 8'h10, "R8");

    // R9 12-hour presentation
    wr(4'h8, 8'h08);
    wr(4'h2, 8'h00); rd(4'h2, 8'h12, "R9");
    wr(4'h2, 8'h13); rd(4'h2, 8'h81, "R9");
    wr(4'h2, 8'h12); rd(4'h2, 8'h92, "R9");
    wr(4'h2, 8'h09); rd(4'h2, 8'h09, "R9");
    wr(4'h2, 8'h23); rd(4'h2, 8'h91, "R9");
    wr(4'h8, 8'h00); rd(4'h2, 8'h23, "R9");

    // R12 write beats a coincident step
    load(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'h8, 8'h01);
    pulses(DIV - 1);
    @(negedge clk); tick = 1'b1; addr = 4'h0; wdata = 8'h40; we = 1'b1;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    rd(4'h0, 8'h40, "R12");
    pulses(DIV);
    rd(4'h0, 8'h41, "R12");

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule